// File: doc/BRIEF.md
# Bit-Serial Second-Order Recursive Filter

This block is a second-order recursive (biquad) filter. It uses distributed arithmetic, so it has no multipliers. A single table holds the sum of every subset of the five filter coefficients: three applied to the current and two past inputs, and two applied to the two past outputs. Each computation cycle, the table is addressed by one bit from each of five tap shift registers. The looked-up value is shifted by the bit weight and added into an accumulator. On the sign-bit cycle it is subtracted instead.

A sample arrives in parallel on `in_data` with `in_valid`. The block then works through the sample bits, least significant first. The finished result comes out in parallel on `out_data` with a one-cycle `out_valid` pulse. The same result is loaded in parallel into the y[n-1] tap for the next sample, and the old y[n-1] moves down to y[n-2].

The sequencer has three states:

- `ST_IDLE` waits for a sample. Transition *accept* (`in_valid` high) leads to `ST_SHIFT`.
- `ST_SHIFT` performs one table lookup per sample bit. Transition *last bit* (the bit counter at `DATA_W-1`) leads to `ST_FINISH`.
- `ST_FINISH` publishes the result and updates the delay taps. Transition *publish* always returns to `ST_IDLE`.

Coefficients are signed fixed-point parameters with `FRAC` fraction bits.

Top module: `biquad_da`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0. All four delay values (x[n-1], x[n-2], y[n-1], y[n-2]) are 0, so the first output depends only on the first sample.
- R2: Each output equals the low `DATA_W` bits of floor((B0·x[n] + B1·x[n-1] + B2·x[n-2] + A1·y[n-1] + A2·y[n-2]) / 2^FRAC), in two's complement. The result wraps on overflow and is never saturated.
- R3: The coefficient table has 32 entries. Address bit 0 comes from x[n], bit 1 from x[n-1], bit 2 from x[n-2], bit 3 from y[n-1] and bit 4 from y[n-2]. Each entry is the sum of the coefficients whose address bit is 1.
- R4: Sample bits are taken least significant first, with weight 2^j. The lookup for bit `DATA_W-1` (the sign bit) is subtracted, so full-scale negative samples are exact.
- R5: `in_valid` is accepted on a rising edge in `ST_IDLE`. `out_valid` is a one-cycle pulse that becomes visible after the `DATA_W+1`-th rising edge following the accepting edge.
- R6: `in_valid` asserted in `ST_SHIFT` or `ST_FINISH` is ignored. It does not change the running result, the delay taps or later outputs.
- R7: On each output, y[n-1] is loaded in parallel with the new result. The old y[n-1] moves to y[n-2], x[n-1] moves to x[n-2], and the accepted sample becomes x[n-1].
- R8: `out_data` holds its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample, signed |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W | Filter output, signed |

## Verification
An impulse exposes the table addressing. If an address bit were wired to the wrong tap, the wrong coefficient would appear at the wrong position in the response. Full-scale negative and positive samples target the sign-bit cycle. A design that added the sign-bit term instead of subtracting it would be off by 2^DATA_W times the coefficient sum on every negative sample. Samples with noise on `in_valid` while the block is busy catch a sequencer that restarts mid-computation: its latency and value would both go wrong. Long random runs compare against an integer model of the recursion, so a y[n-2] tap that missed its update would show up as a drifting result.

// File: rtl/biquad_da_pkg.sv
package biquad_da_pkg;

    // number of taps feeding the coefficient table
    localparam int NUM_TAPS  = 5;
    localparam int TAB_DEPTH = 1 << NUM_TAPS;

    // tap order inside the table address
    localparam int TAP_X0 = 0;
    localparam int TAP_X1 = 1;
    localparam int TAP_X2 = 2;
    localparam int TAP_Y1 = 3;
    localparam int TAP_Y2 = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } da_state_e;

endpackage

// File: rtl/da_coef_table.sv
module da_coef_table
    import biquad_da_pkg::*;
#(
    parameter int ACC_W = 20,
    parameter int B0    = 64,
    parameter int B1    = 96,
    parameter int B2    = 64,
    parameter int A1    = 120,
    parameter int A2    = -60
) (
    input  logic [NUM_TAPS-1:0]     addr,
    output logic signed [ACC_W-1:0] entry
);

    logic signed [ACC_W-1:0] table_w [TAB_DEPTH];

    // one entry per subset of coefficients, computed at elaboration
    for (genvar a = 0; a < TAB_DEPTH; a++) begin : g_entry
        localparam int SEL_X0 = (a >> TAP_X0) & 1;
        localparam int SEL_X1 = (a >> TAP_X1) & 1;
        localparam int SEL_X2 = (a >> TAP_X2) & 1;
        localparam int SEL_Y1 = (a >> TAP_Y1) & 1;
        localparam int SEL_Y2 = (a >> TAP_Y2) & 1;
        localparam int VALUE  = SEL_X0 * B0 + SEL_X1 * B1 + SEL_X2 * B2
                              + SEL_Y1 * A1 + SEL_Y2 * A2;
        assign table_w[a] = ACC_W'(VALUE);
    end

    assign entry = table_w[addr];

endmodule

// File: rtl/da_tap_bank.sv
module da_tap_bank
    import biquad_da_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift_en,
    input  logic                update,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [DATA_W-1:0]   y_new,
    output logic [NUM_TAPS-1:0] addr
);

    // held delay values
    logic [DATA_W-1:0] x0_q, x1_q, x2_q, y1_q, y2_q;
    // working shift registers, one per tap
    logic [DATA_W-1:0] sh_q [NUM_TAPS];
    logic [DATA_W-1:0] src  [NUM_TAPS];

    always_comb begin
        src[TAP_X0] = in_data;
        src[TAP_X1] = x1_q;
        src[TAP_X2] = x2_q;
        src[TAP_Y1] = y1_q;
        src[TAP_Y2] = y2_q;
    end

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q[t] <= '0;
            end else if (load) begin
                sh_q[t] <= src[t];
            end else if (shift_en) begin
                sh_q[t] <= sh_q[t] >> 1;
            end
        end
        assign addr[t] = sh_q[t][0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0_q <= '0;
            x1_q <= '0;
            x2_q <= '0;
            y1_q <= '0;
            y2_q <= '0;
        end else begin
            if (load) begin
                x0_q <= in_data;
            end
            if (update) begin
                x2_q <= x1_q;
                x1_q <= x0_q;
                y2_q <= y1_q;
                y1_q <= y_new;
            end
        end
    end

    AST_Y1_PARALLEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (y1_q == $past(y_new))); // R7
    AST_Y2_FROM_Y1: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (y2_q == $past(y1_q) && x2_q == $past(x1_q))); // R7
    AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> ($stable(x1_q) && $stable(x2_q) && $stable(y1_q) && $stable(y2_q))); // R6

endmodule

// File: rtl/da_serial_acc.sv
module da_serial_acc #(
    parameter int DATA_W = 12,
    parameter int FRAC   = 8,
    parameter int ACC_W  = 20,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    add_en,
    input  logic                    sub_en,
    input  logic [IDX_W-1:0]        bit_idx,
    input  logic signed [ACC_W-1:0] entry,
    output logic [DATA_W-1:0]       y_out
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] term;

    // weight the table value by the current bit position
    assign term = entry <<< bit_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= sub_en ? (acc_q - term) : (acc_q + term);
        end
    end

    // modular accumulator: upper bits equal the floor-shifted, wrapped result
    assign y_out = acc_q[ACC_W-1:FRAC];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0)); // R2
    AST_SUB_ONLY_WHILE_ADDING: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> add_en); // R4
    AST_SUB_ON_SIGN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> (bit_idx == IDX_W'(DATA_W - 1))); // R4

endmodule

// File: rtl/da_biquad_ctrl.sv
module da_biquad_ctrl
    import biquad_da_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             load,
    output logic             shift_en,
    output logic             sub_en,
    output logic             update,
    output logic [IDX_W-1:0] bit_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    da_state_e         state_q, state_d;
    logic [IDX_W-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_SHIFT;         // accept
            ST_SHIFT:  if (cnt_q == LAST_IDX) state_d = ST_FINISH; // last bit
            ST_FINISH: state_d = ST_IDLE;                         // publish
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        shift_en = 1'b0;
        sub_en   = 1'b0;
        update   = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = in_valid;
            ST_SHIFT: begin
                shift_en = 1'b1;
                sub_en   = (cnt_q == LAST_IDX);
            end
            ST_FINISH: update = 1'b1;
            default: ;
        endcase
    end

    assign bit_idx = cnt_q;

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid) |=> (state_q == ST_SHIFT && cnt_q == '0)); // R5
    AST_LAST_BIT_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_q == LAST_IDX) |=> (state_q == ST_FINISH)); // R5
    AST_FINISH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE)); // R5
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_q != LAST_IDX) |=> (state_q == ST_SHIFT && cnt_q == $past(cnt_q) + 1'b1)); // R6

endmodule

// File: rtl/biquad_da.sv
module biquad_da
    import biquad_da_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int COEF_W = 12,
    parameter int FRAC   = 8,
    parameter int B0     = 64,
    parameter int B1     = 96,
    parameter int B2     = 64,
    parameter int A1     = 120,
    parameter int A2     = -60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    // only the bits the wrapped output needs are kept in the accumulator
    localparam int ACC_W = FRAC + DATA_W;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic                    load, shift_en, sub_en, update;
    logic [IDX_W-1:0]        bit_idx;
    logic [NUM_TAPS-1:0]     addr;
    logic signed [ACC_W-1:0] entry;
    logic [DATA_W-1:0]       y_new;

    da_biquad_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .load     (load),
        .shift_en (shift_en),
        .sub_en   (sub_en),
        .update   (update),
        .bit_idx  (bit_idx)
    );

    da_tap_bank #(.DATA_W(DATA_W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .update   (update),
        .in_data  (in_data),
        .y_new    (y_new),
        .addr     (addr)
    );

    da_coef_table #(
        .ACC_W (ACC_W),
        .B0 (B0), .B1 (B1), .B2 (B2), .A1 (A1), .A2 (A2)
    ) u_table (
        .addr  (addr),
        .entry (entry)
    );

    da_serial_acc #(
        .DATA_W (DATA_W), .FRAC (FRAC), .ACC_W (ACC_W), .IDX_W (IDX_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .add_en  (shift_en),
        .sub_en  (sub_en),
        .bit_idx (bit_idx),
        .entry   (entry),
        .y_out   (y_new)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= update;
            if (update) begin
                out_data <= y_new;
            end
        end
    end

    // coefficients must fit the declared coefficient width
    initial begin
        AST_COEF_RANGE: assert (B0 < (1 << (COEF_W - 1)) && B0 >= -(1 << (COEF_W - 1))
                             && A1 < (1 << (COEF_W - 1)) && A2 >= -(1 << (COEF_W - 1))); // R3
    end

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R8

endmodule

// File: tb/biquad_da_tb.sv
module biquad_da_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 12;
    localparam int FRAC   = 8;
    localparam int B0 = 64;
    localparam int B1 = 96;
    localparam int B2 = 64;
    localparam int A1 = 120;
    localparam int A2 = -60;
    localparam int LAT = DATA_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    biquad_da #(
        .DATA_W (DATA_W), .COEF_W (12), .FRAC (FRAC),
        .B0 (B0), .B1 (B1), .B2 (B2), .A1 (A1), .A2 (A2)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // integer model of the recursion, wrapped to the sample width
    function automatic int model_step(input int x0);
        longint sum;
        longint shifted;
        logic signed [DATA_W-1:0] wrapped;
        sum = longint'(B0) * x0 + longint'(B1) * mx1 + longint'(B2) * mx2
            + longint'(A1) * my1 + longint'(A2) * my2;
        shifted = sum >>> FRAC;
        wrapped = shifted[DATA_W-1:0];
        return int'(wrapped);
    endfunction

    function automatic int as_signed(input logic [DATA_W-1:0] v);
        logic signed [DATA_W-1:0] s;
        s = v;
        return int'(s);
    endfunction

    task automatic run_sample(input int x, input bit noisy, input string req);
        int k;
        bit got;
        int exp_y;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DATA_W'(x);
        @(negedge clk);
        in_valid = noisy;
        in_data  = DATA_W'($urandom);
        check(out_valid == 1'b0, "R5", out_valid, 0);
        k = 0;
        got = 1'b0;
        while (!got && k < LAT + 8) begin
            @(negedge clk);
            k++;
            if (out_valid) got = 1'b1;
            if (noisy) begin
                in_valid = (k <= DATA_W);
                in_data  = DATA_W'($urandom);
            end
        end
        in_valid = 1'b0;
        exp_y = model_step(x);
        mx2 = mx1; mx1 = x; my2 = my1; my1 = exp_y;
        check(k == LAT, "R5 latency", k, LAT);
        check(as_signed(out_data) == exp_y, req, as_signed(out_data), exp_y);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 pulse", out_valid, 0);
        check(as_signed(out_data) == exp_y, "R8", as_signed(out_data), exp_y);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1B1D));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_data == '0, "R1", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);

        // R1/R3: impulse, first output only sees B0, then B1, B2 and feedback
        run_sample(1000, 1'b0, "R1");
        for (int i = 0; i < 6; i++) run_sample(0, 1'b0, "R3");

        // R4: full-scale and sign-bit corner samples
        run_sample(-2048, 1'b0, "R4");
        run_sample(2047, 1'b0, "R4");
        run_sample(-1, 1'b0, "R4");
        run_sample(-2048, 1'b0, "R4");
        run_sample(-2048, 1'b0, "R4");
        run_sample(1, 1'b0, "R4");

        // R6: strobe noise while busy
        for (int i = 0; i < 12; i++) run_sample(int'($urandom_range(4095)) - 2048, 1'b1, "R6");

        // R2/R7: random stream through the recursion
        for (int i = 0; i < 120; i++) run_sample(int'($urandom_range(4095)) - 2048, 1'b0, "R2 R7");

        // R8: output holds while idle
        repeat (5) begin
            @(negedge clk);
            check(as_signed(out_data) == my1, "R8", as_signed(out_data), my1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule